// File: doc/BRIEF.md
# Paging Call Termination Word Generator

This block follows one paging call from the moment an external address matcher reports a call start, and decides the cycle in which that call ends. A call ends when an address codeword arrives. It also ends on a message codeword, but only when enhanced termination is enabled. In data-fail mode it also ends when a batch boundary arrives without a detected sync word. A host command can end the call at any time. When the call ends, the block emits a one-cycle valid pulse and an 8-bit status word. The word records whether the end was forced, the index of the last sync word that was seen, a data-fail flag and a narrowed error class.

Codeword error classes and sync indices are computed upstream and arrive on strobe-qualified inputs. The data-fail flag follows one of two rules, chosen by the reception mode. In data-receive mode it reports uncorrectable message data within the current batch. In data-fail mode it reports a missing sync word at the start of the current batch. Widths are parameters. A build-time option removes enhanced termination altogether.

Top module: `pcall_term_gen`

## Requirements
- R1: With default widths the word is `{FT, S[2:0], DF, E[2:0]}`: bit 7 is FT, bits 6:4 are the sync index, bit 3 is DF and bits 2:0 are the error field. Bit 2 is always 0.
- R2: `term_valid` is high for exactly the one cycle after a termination event, and only for events that occur while a call is active.
- R3: An address codeword (`cw_valid` with `cw_is_addr`=1) during an active call ends the call.
- R4: A message codeword (`cw_is_addr`=0) ends an active call only when `enh_en`=1 and the block is built with `ENH_SUPPORT`=1. Otherwise it does not end the call.
- R5: When `df_mode`=1, a `batch_start` with `sync_hit`=0 during an active call ends the call.
- R6: FT is 1 when `force_term` was high in the terminating cycle, and 0 otherwise.
- R7: When `df_mode`=0, DF is 1 if some message codeword with error class 3'b111 arrived since the latest `batch_start`. The codeword that ends the call does not count.
- R8: When `df_mode`=1, DF is 1 exactly when the latest `batch_start` had `sync_hit`=0.
- R9: S holds `sync_idx` from the latest `batch_start` with `sync_hit`=1. It is 0 if no such event has occurred since reset.
- R10: The word holds its value in every cycle that has no new termination.
- R11: A synchronous active-low reset clears `term_valid`, the word, the call-active state and all batch history.
- R12: E[1:0] holds the low two bits of `cw_err` when `cw_valid` is high in the terminating cycle, and 0 when it is not.
- R13: `call_start` makes a call active. A termination clears the call-active state, unless `call_start` is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_start | input | 1 | Strobe: a call begins |
| cw_valid | input | 1 | Strobe qualifying the codeword inputs |
| cw_is_addr | input | 1 | 1 = address codeword, 0 = message codeword |
| cw_err | input | ERR_W | Error class of the codeword; all ones = uncorrectable |
| batch_start | input | 1 | Strobe: a batch boundary (sync slot) |
| sync_hit | input | 1 | A sync word was recognised in this slot |
| sync_idx | input | SIDX_W | Index of the recognised sync word |
| df_mode | input | 1 | 0 = data-receive mode, 1 = data-fail mode |
| enh_en | input | 1 | Enhanced termination on message codewords |
| force_term | input | 1 | Host command: end the call now |
| term_valid | output | 1 | One-cycle termination pulse |
| term_word | output | 2+SIDX_W+ERR_W | Terminator status word |

## Verification
The bench builds two copies side by side with the default 3-bit sync index and 3-bit error class. One copy has `ENH_SUPPORT`=1 and the other has `ENH_SUPPORT`=0, and both receive the same stimulus. With this pairing a single message codeword can end the call in one copy while the call stays active in the other, so both the enhanced termination path and its compiled-out variant can be observed. The default widths give the 8-bit word layout, so every field can be checked against hand-computed values. Mode and enable changes during random traffic make both data-fail rules reachable.

// File: rtl/pterm_pkg.sv
package pterm_pkg;
   localparam int DEF_SIDX_W = 3;
   localparam int DEF_ERR_W  = 3;

   typedef enum logic {
      MODE_RECV = 1'b0,
      MODE_FAIL = 1'b1
   } rx_mode_e;
endpackage

// File: rtl/pterm_batch_track.sv
module pterm_batch_track #(
   parameter int SIDX_W = pterm_pkg::DEF_SIDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              batch_start,
   input  logic              sync_hit,
   input  logic [SIDX_W-1:0] sync_idx,
   input  logic              data_bad,
   output logic              bad_eff,
   output logic              nosync_eff,
   output logic [SIDX_W-1:0] sidx_eff
);
   logic              bad_q;
   logic              nosync_q;
   logic [SIDX_W-1:0] sidx_q;

   // A batch boundary in this cycle takes effect before any codeword in it.
   always_comb begin
      bad_eff    = batch_start ? 1'b0 : bad_q;
      nosync_eff = batch_start ? ~sync_hit : nosync_q;
      sidx_eff   = (batch_start & sync_hit) ? sync_idx : sidx_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bad_q    <= 1'b0;
         nosync_q <= 1'b0;
         sidx_q   <= '0;
      end else begin
         bad_q    <= bad_eff | data_bad;
         nosync_q <= nosync_eff;
         sidx_q   <= sidx_eff;
      end
   end
endmodule

// File: rtl/pterm_call_ctl.sv
module pterm_call_ctl #(
   parameter bit ENH_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic call_start,
   input  logic force_term,
   input  logic cw_valid,
   input  logic cw_is_addr,
   input  logic enh_en,
   input  logic nosync_now,
   input  logic df_mode,
   output logic call_active,
   output logic msg_ends,
   output logic term_fire
);
   logic enh_eff;
   logic active_q;

   generate
      if (ENH_SUPPORT) begin : g_enh
         assign enh_eff = enh_en;
      end else begin : g_noenh
         logic unused_enh;
         assign unused_enh = enh_en;
         assign enh_eff    = 1'b0;
      end
   endgenerate

   assign msg_ends  = active_q & cw_valid & ~cw_is_addr & enh_eff;
   assign term_fire = active_q & (force_term
                                  | (cw_valid & cw_is_addr)
                                  | (cw_valid & ~cw_is_addr & enh_eff)
                                  | (nosync_now & (df_mode == pterm_pkg::MODE_FAIL)));

   always_ff @(posedge clk) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= call_start | (active_q & ~term_fire);
   end

   assign call_active = active_q;
endmodule

// File: rtl/pterm_word_fmt.sv
module pterm_word_fmt #(
   parameter int SIDX_W = pterm_pkg::DEF_SIDX_W,
   parameter int ERR_W  = pterm_pkg::DEF_ERR_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       term_fire,
   input  logic                       ft,
   input  logic [SIDX_W-1:0]          sidx,
   input  logic                       df,
   input  logic [ERR_W-2:0]           err_low,
   output logic                       term_valid,
   output logic [2+SIDX_W+ERR_W-1:0]  term_word
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         term_valid <= 1'b0;
         term_word  <= '0;
      end else begin
         term_valid <= term_fire;
         if (term_fire) term_word <= {ft, sidx, df, 1'b0, err_low};
      end
   end
endmodule

// File: rtl/pcall_term_gen.sv
module pcall_term_gen #(
   parameter int SIDX_W      = pterm_pkg::DEF_SIDX_W,
   parameter int ERR_W       = pterm_pkg::DEF_ERR_W,
   parameter bit ENH_SUPPORT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      call_start,
   input  logic                      cw_valid,
   input  logic                      cw_is_addr,
   input  logic [ERR_W-1:0]          cw_err,
   input  logic                      batch_start,
   input  logic                      sync_hit,
   input  logic [SIDX_W-1:0]         sync_idx,
   input  logic                      df_mode,
   input  logic                      enh_en,
   input  logic                      force_term,
   output logic                      term_valid,
   output logic [2+SIDX_W+ERR_W-1:0] term_word
);
   localparam int              WORD_W = 2 + SIDX_W + ERR_W;
   localparam int              DF_BIT = ERR_W;
   localparam logic [ERR_W-1:0] UNCORR = '1;

   generate
      if (ERR_W < 2) begin : g_chk_err
         $error("ERR_W must be at least 2");
      end
      if (SIDX_W < 1) begin : g_chk_sidx
         $error("SIDX_W must be at least 1");
      end
   endgenerate

   logic              call_active, msg_ends, term_fire;
   logic              data_bad, bad_eff, nosync_eff;
   logic [SIDX_W-1:0] sidx_eff;
   logic [ERR_W-2:0]  err_low;
   logic              df_sel;

   // Uncorrectable message data counts unless that codeword ends the call.
   assign data_bad = cw_valid & ~cw_is_addr & (cw_err == UNCORR) & ~msg_ends;
   assign err_low  = cw_valid ? cw_err[ERR_W-2:0] : '0;
   assign df_sel   = (df_mode == pterm_pkg::MODE_FAIL) ? nosync_eff : bad_eff;

   pterm_batch_track #(.SIDX_W(SIDX_W)) u_batch (
      .clk(clk), .rst_n(rst_n), .batch_start(batch_start), .sync_hit(sync_hit),
      .sync_idx(sync_idx), .data_bad(data_bad), .bad_eff(bad_eff),
      .nosync_eff(nosync_eff), .sidx_eff(sidx_eff)
   );

   pterm_call_ctl #(.ENH_SUPPORT(ENH_SUPPORT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .call_start(call_start), .force_term(force_term),
      .cw_valid(cw_valid), .cw_is_addr(cw_is_addr), .enh_en(enh_en),
      .nosync_now(batch_start & ~sync_hit), .df_mode(df_mode),
      .call_active(call_active), .msg_ends(msg_ends), .term_fire(term_fire)
   );

   pterm_word_fmt #(.SIDX_W(SIDX_W), .ERR_W(ERR_W)) u_fmt (
      .clk(clk), .rst_n(rst_n), .term_fire(term_fire), .ft(force_term),
      .sidx(sidx_eff), .df(df_sel), .err_low(err_low),
      .term_valid(term_valid), .term_word(term_word)
   );

   assert_only_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      term_valid |-> $past(call_active));

   assert_addr_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (call_active & cw_valid & cw_is_addr) |=> term_valid);

   assert_nosync_df_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (call_active & batch_start & ~sync_hit & df_mode) |=> (term_valid & term_word[DF_BIT]));

   assert_forced_ft_R6: assert property (@(posedge clk) disable iff (!rst_n)
      term_valid |-> (term_word[WORD_W-1] == $past(force_term)));

   assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !term_valid |-> $stable(term_word));
endmodule

// File: tb/tb_pcall_term_gen.sv
module tb_pcall_term_gen;
   logic clk = 1'b0;
   logic rst_n;
   logic call_start, cw_valid, cw_is_addr, batch_start, sync_hit, df_mode, enh_en, force_term;
   logic [2:0] cw_err, sync_idx;
   logic       tv   [2];
   logic [7:0] tw   [2];

   int tests = 0;
   int fails = 0;
   bit cmp_en = 1'b0;

   // Reference state per variant: 0 = enhanced support, 1 = without.
   bit       m_act [2];
   bit       m_bad [2];
   bit       m_nos [2];
   int       m_sid [2];
   bit       m_ev  [2];
   int       m_word[2];

   always #10 clk = ~clk;

   pcall_term_gen dut (
      .clk(clk), .rst_n(rst_n), .call_start(call_start), .cw_valid(cw_valid),
      .cw_is_addr(cw_is_addr), .cw_err(cw_err), .batch_start(batch_start),
      .sync_hit(sync_hit), .sync_idx(sync_idx), .df_mode(df_mode), .enh_en(enh_en),
      .force_term(force_term), .term_valid(tv[0]), .term_word(tw[0])
   );

   pcall_term_gen #(.ENH_SUPPORT(1'b0)) dut_ne (
      .clk(clk), .rst_n(rst_n), .call_start(call_start), .cw_valid(cw_valid),
      .cw_is_addr(cw_is_addr), .cw_err(cw_err), .batch_start(batch_start),
      .sync_hit(sync_hit), .sync_idx(sync_idx), .df_mode(df_mode), .enh_en(enh_en),
      .force_term(force_term), .term_valid(tv[1]), .term_word(tw[1])
   );

   task automatic chk(input string req, input int actual, input int expected);
      tests++;
      if (actual != expected) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
      end
   endtask

   always @(posedge clk) begin
      for (int v = 0; v < 2; v++) begin
         if (!rst_n) begin
            m_act[v] = 0; m_bad[v] = 0; m_nos[v] = 0; m_sid[v] = 0;
            m_ev[v] = 0;  m_word[v] = 0;
         end else begin
            bit enh, bad_e, nos_e, term, df;
            int sid_e;
            enh   = (v == 0) && enh_en;
            bad_e = batch_start ? 1'b0 : m_bad[v];
            nos_e = batch_start ? !sync_hit : m_nos[v];
            sid_e = (batch_start && sync_hit) ? int'(sync_idx) : m_sid[v];
            term  = m_act[v] && (force_term || (cw_valid && cw_is_addr) ||
                    (cw_valid && !cw_is_addr && enh) || (batch_start && !sync_hit && df_mode));
            df    = df_mode ? nos_e : bad_e;
            m_ev[v] = term;
            if (term)
               m_word[v] = (int'(force_term) * 128) + sid_e * 16 + int'(df) * 8 +
                           (cw_valid ? int'(cw_err) % 4 : 0);
            m_bad[v] = bad_e || (cw_valid && !cw_is_addr && cw_err == 3'b111 && !(m_act[v] && enh));
            m_nos[v] = nos_e;
            m_sid[v] = sid_e;
            m_act[v] = call_start || (m_act[v] && !term);
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         for (int v = 0; v < 2; v++) begin
            chk("R2 valid", int'(tv[v]), int'(m_ev[v]));
            chk("R6 ft", int'(tw[v][7]), m_word[v] / 128);
            chk("R9 sync index", int'(tw[v][6:4]), (m_word[v] / 16) % 8);
            chk("R7 df", int'(tw[v][3]), (m_word[v] / 8) % 2);
            chk("R1 e3", int'(tw[v][2]), 0);
            chk("R12 err", int'(tw[v][1:0]), m_word[v] % 4);
         end
      end
   end

   task automatic clr();
      call_start = 0; cw_valid = 0; cw_is_addr = 0; cw_err = 0;
      batch_start = 0; sync_hit = 0; sync_idx = 0; force_term = 0;
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst_n = 0; df_mode = 0; enh_en = 0; clr();
      repeat (3) cyc();
      chk("R11 reset valid", int'(tv[0]), 0);
      chk("R11 reset word", int'(tw[0]), 0);
      cmp_en = 1;
      rst_n = 1;
      cyc();
      // R3 R9 R12: address ends call
      batch_start = 1; sync_hit = 1; sync_idx = 5; call_start = 1; cyc(); clr();
      chk("R13 no end yet", int'(tv[0]), 0);
      cw_valid = 1; cw_is_addr = 1; cw_err = 3'b010; cyc(); clr();
      chk("R3 addr end", int'(tv[0]), 1);
      chk("R12 word", int'(tw[0]), 'h52);
      chk("R9 word ne", int'(tw[1]), 'h52);
      cyc();
      chk("R2 single pulse", int'(tv[0]), 0);
      chk("R10 hold", int'(tw[0]), 'h52);
      // R7: uncorrectable data in receive mode
      batch_start = 1; sync_hit = 1; sync_idx = 2; call_start = 1; cyc(); clr();
      cw_valid = 1; cw_err = 3'b111; cyc(); clr();
      chk("R4 msg no end", int'(tv[0]), 0);
      cw_valid = 1; cw_is_addr = 1; cyc(); clr();
      chk("R7 df recv", int'(tw[0]), 'h28);
      // R5 R8: missing sync in data-fail mode
      df_mode = 1; call_start = 1; cyc(); clr();
      batch_start = 1; sync_hit = 0; cyc(); clr();
      chk("R5 nosync end", int'(tv[0]), 1);
      chk("R8 df fail", int'(tw[0]), 'h28);
      // R6 forced
      call_start = 1; cyc(); clr();
      force_term = 1; cyc(); clr();
      chk("R6 forced word", int'(tw[0]), 'hA8);
      // no call active: address ignored
      cw_valid = 1; cw_is_addr = 1; cyc(); clr();
      chk("R2 inactive", int'(tv[0]), 0);
      chk("R10 inactive hold", int'(tw[0]), 'hA8);
      // R4 enhanced termination on message
      df_mode = 0; enh_en = 1;
      batch_start = 1; sync_hit = 1; sync_idx = 3; call_start = 1; cyc(); clr();
      cw_valid = 1; cw_err = 3'b001; cyc(); clr();
      chk("R4 enh end", int'(tv[0]), 1);
      chk("R4 enh word", int'(tw[0]), 'h31);
      chk("R4 no-enh build", int'(tv[1]), 0);
      chk("R4 no-enh hold", int'(tw[1]), 'hA8);
      enh_en = 0; force_term = 1; cyc(); clr();
      chk("R13 ne still active", int'(tv[1]), 1);
      // random traffic
      for (int i = 0; i < 6000; i++) begin
         clr();
         call_start  = ($urandom_range(0, 99) < 15);
         cw_valid    = ($urandom_range(0, 99) < 40);
         cw_is_addr  = ($urandom_range(0, 99) < 20);
         cw_err      = ($urandom_range(0, 4) == 0) ? 3'b111 : 3'($urandom_range(0, 7));
         batch_start = ($urandom_range(0, 15) == 0);
         sync_hit    = ($urandom_range(0, 3) != 0);
         sync_idx    = 3'($urandom_range(0, 7));
         force_term  = ($urandom_range(0, 99) < 3);
         if (i % 64 == 0) begin
            df_mode = 1'($urandom_range(0, 1));
            enh_en  = 1'($urandom_range(0, 1));
         end
         if (i == 3000) rst_n = 0;
         if (i == 3003) rst_n = 1;
         cyc();
      end
      clr();
      rst_n = 0; cyc(); cyc();
      chk("R11 final reset valid", int'(tv[1]), 0);
      chk("R11 final reset word", int'(tw[1]), 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule